// File: doc/BRIEF.md
# Variable-Length Serial Data Shifter

This block is the data path behind a two-wire serial port whose data unit can be 1 to 8 bits long, with the length chosen at run time. On the receive side, a strobe marks each bit that is sampled from the data line. The bit is shifted into a private shift register. When the selected number of bits has been collected, the unit is copied, right-justified, into a 16-bit register that the CPU reads.

On the transmit side, the CPU writes a value whose low bits hold the unit. The block presents the unit on its serial output one bit per shift strobe, most significant bit of the unit first.

A direction input chooses which of the two strobes advances the shared bit counter. A one-cycle completion flag marks the end of each unit. Bus timing, acknowledge handling and any queueing are left to the surrounding controller.

Top module: `var_len_shifter`

## Requirements
- R1: The 3-bit length select gives the unit length: code 0 selects 8 bits, and codes 1 through 7 select that many bits. Completion follows exactly that many active strobes.
- R2: On receive (direction 0), the bit sampled first lands in bit N-1 of the read data and the bit sampled last lands in bit 0, where N is the selected length.
- R3: After a receive unit completes, bits N through 7 of the read data are zero.
- R4: Bits 15 to 8 of the read data are always zero, and CPU writes never change the read data.
- R5: The read data changes only when a receive unit completes. A partly received unit leaves the previous value visible.
- R6: In transmit (direction 1), after a CPU write the serial output shows bit N-1 of the written value. Each shift strobe advances to the next lower bit. Bits of the write at or above N have no effect.
- R7: The completion flag is high for exactly the one clock that follows the edge on which the Nth active strobe is taken. The counter then restarts, so back-to-back units each complete after N strobes.
- R8: The strobe of the inactive direction has no effect. It does not advance the counter, does not change the read data or the serial output, and does not raise the completion flag.
- R9: After reset, the read data, the serial output and the completion flag are all zero.
- R10: A CPU write while in transmit restarts the bit counter, even in the middle of a unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_sel | input | 3 | Unit length code (0 = 8 bits, k = k bits) |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| rx_bit | input | 1 | Serial data in |
| rx_strobe | input | 1 | Sample strobe for rx_bit |
| tx_strobe | input | 1 | Shift strobe for the serial output |
| tx_bit | output | 1 | Serial data out |
| cpu_wr_en | input | 1 | CPU write of transmit data |
| cpu_wr_data | input | 16 | CPU write value; the unit sits in the low bits |
| cpu_rd_data | output | 16 | Received unit, zero-extended |
| unit_done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every length code with random data. It aims at the 8-bit code 0 and the 1-bit code, where an off-by-one counter would finish a unit early or late. It also checks stale high bits left in the shift register by a longer earlier unit; a design that did not mask them would show leftover bits above N. Stray strobes in the wrong direction, and a CPU write in the middle of a unit, are exercised too. A design that shared the counter carelessly would finish the next unit early or show the wrong first bit.

// File: rtl/var_len_shifter.sv
module var_len_shifter #(
  parameter int REG_W  = 16,
  parameter int UNIT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(UNIT_W)-1:0] len_sel,
  input  logic                      dir_tx,
  input  logic                      rx_bit,
  input  logic                      rx_strobe,
  input  logic                      tx_strobe,
  output logic                      tx_bit,
  input  logic                      cpu_wr_en,
  input  logic [REG_W-1:0]          cpu_wr_data,
  output logic [REG_W-1:0]          cpu_rd_data,
  output logic                      unit_done
);
  localparam int CNT_W = $clog2(UNIT_W);
  localparam int LEN_W = CNT_W + 1;

  logic [LEN_W-1:0]  len;
  logic [UNIT_W-1:0] len_mask;
  logic [CNT_W-1:0]  cnt;
  logic [UNIT_W-1:0] rx_sr, rx_next, rx_data, tx_hold;
  logic [CNT_W-1:0]  tx_idx;
  logic              step, last;

  assign len  = (len_sel == '0) ? LEN_W'(UNIT_W) : {1'b0, len_sel};
  assign step = dir_tx ? tx_strobe : rx_strobe;
  assign last = ({1'b0, cnt} == len - LEN_W'(1));

  always_comb
    for (int i = 0; i < UNIT_W; i++)
      len_mask[i] = (i < int'(len));

  assign rx_next     = {rx_sr[UNIT_W-2:0], rx_bit};
  assign tx_idx      = CNT_W'(len - LEN_W'(1) - {1'b0, cnt});
  assign tx_bit      = tx_hold[tx_idx];
  assign cpu_rd_data = {{(REG_W-UNIT_W){1'b0}}, rx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_sr     <= '0;
      rx_data   <= '0;
      tx_hold   <= '0;
      unit_done <= 1'b0;
    end else begin
      unit_done <= step && last;
      if (dir_tx && cpu_wr_en) begin
        tx_hold <= cpu_wr_data[UNIT_W-1:0];
        cnt     <= '0;
      end else if (step) begin
        cnt <= last ? '0 : cnt + CNT_W'(1);
      end
      if (!dir_tx && rx_strobe) begin
        rx_sr <= rx_next;
        if (last) rx_data <= rx_next & len_mask;
      end
    end
  end

  assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> $past(step) && ({1'b0, $past(cnt)} == $past(len) - LEN_W'(1)));

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_done |-> $stable(rx_data));

  assert_rx_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !$past(dir_tx)) |-> ((rx_data & ~$past(len_mask)) == '0));

  assert_write_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && cpu_wr_en) |=> (cnt == '0));

  assert_idle_counter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(dir_tx && cpu_wr_en)) |=> $stable(cnt));
endmodule

// File: tb/var_len_shifter_tb.sv
module var_len_shifter_tb;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  len_sel = 0;
  logic        dir_tx = 0, rx_bit = 0, rx_strobe = 0, tx_strobe = 0;
  logic        tx_bit, unit_done, cpu_wr_en = 0;
  logic [15:0] cpu_wr_data = 0, cpu_rd_data;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  var_len_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .dir_tx(dir_tx),
    .rx_bit(rx_bit), .rx_strobe(rx_strobe), .tx_strobe(tx_strobe),
    .tx_bit(tx_bit), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .unit_done(unit_done));

  function automatic int unit_len(input logic [2:0] s);
    return (s == 0) ? 8 : int'(s);
  endfunction

  function automatic logic [15:0] exp_rx(input logic [2:0] s, input logic [7:0] d);
    logic [15:0] r = 0;
    for (int i = 0; i < unit_len(s); i++) r[i] = d[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rx_unit(input logic [2:0] s, input logic [7:0] d);
    int n = unit_len(s);
    logic [15:0] prev;
    len_sel = s; dir_tx = 0;
    @(negedge clk);
    prev = cpu_rd_data;
    for (int j = 0; j <= n; j++) begin
      if (j > 0) begin
        check(unit_done == (j == n), "R1/R7 rx done timing", {15'd0, unit_done}, {15'd0, j == n});
        if (j < n) check(cpu_rd_data == prev, "R5 rx hold", cpu_rd_data, prev);
      end
      if (j < n) begin rx_strobe = 1; rx_bit = d[n-1-j]; end
      else rx_strobe = 0;
      @(negedge clk);
    end
    check(unit_done == 0, "R7 one-clock pulse", {15'd0, unit_done}, 16'd0);
    check(cpu_rd_data == exp_rx(s, d), "R2/R3/R4 rx data", cpu_rd_data, exp_rx(s, d));
  endtask

  task automatic tx_write(input logic [15:0] w);
    dir_tx = 1; cpu_wr_en = 1; cpu_wr_data = w;
    @(negedge clk);
    cpu_wr_en = 0;
  endtask

  task automatic tx_unit(input logic [2:0] s, input logic [15:0] w);
    int n = unit_len(s);
    len_sel = s;
    tx_write(w);
    for (int j = 0; j < n; j++) begin
      check(tx_bit == w[n-1-j], "R6 tx bit order", {15'd0, tx_bit}, {15'd0, w[n-1-j]});
      tx_strobe = 1;
      @(negedge clk);
      check(unit_done == (j == n-1), "R1/R7 tx done timing", {15'd0, unit_done}, {15'd0, j == n-1});
    end
    tx_strobe = 0;
    check(tx_bit == w[n-1], "R7 tx counter restart", {15'd0, tx_bit}, {15'd0, w[n-1]});
    @(negedge clk);
    check(unit_done == 0, "R7 one-clock pulse", {15'd0, unit_done}, 16'd0);
  endtask

  initial begin
    #100000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check(cpu_rd_data == 0, "R9 reset rd", cpu_rd_data, 0);
    check(tx_bit == 0, "R9 reset tx", {15'd0, tx_bit}, 0);
    check(unit_done == 0, "R9 reset done", {15'd0, unit_done}, 0);
    rst_n = 1;
    @(negedge clk);

    rx_unit(3'd0, 8'hA5);
    rx_unit(3'd0, 8'hFF);
    rx_unit(3'd1, 8'h01);
    rx_unit(3'd3, 8'hFF);
    rx_unit(3'd7, 8'h55);
    tx_unit(3'd0, 16'hFF96);
    tx_unit(3'd1, 16'h0001);
    tx_unit(3'd3, 16'hABF5);

    dir_tx = 1; cpu_wr_en = 1; cpu_wr_data = 16'hFFFF;
    held = cpu_rd_data;
    @(negedge clk);
    cpu_wr_en = 0;
    check(cpu_rd_data == held, "R4 write ignored by rd", cpu_rd_data, held);
    check(cpu_rd_data[15:8] == 0, "R4 upper zero", cpu_rd_data, {8'h00, held[7:0]});

    len_sel = 3'd0;
    tx_write(16'h00C3);
    tx_strobe = 1; repeat (2) @(negedge clk); tx_strobe = 0;
    tx_unit(3'd0, 16'h005A);

    dir_tx = 0; len_sel = 3'd4;
    tx_write(16'h0008); dir_tx = 0;
    held = {15'd0, tx_bit};
    tx_strobe = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(unit_done == 0, "R8 tx strobe ignored in rx", {15'd0, unit_done}, 0);
    end
    tx_strobe = 0;
    check(tx_bit == held[0], "R8 tx bit unchanged", {15'd0, tx_bit}, held);
    rx_unit(3'd4, 8'h09);

    len_sel = 3'd2; dir_tx = 1;
    held = cpu_rd_data;
    rx_strobe = 1; rx_bit = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(unit_done == 0, "R8 rx strobe ignored in tx", {15'd0, unit_done}, 0);
    end
    rx_strobe = 0;
    check(cpu_rd_data == held, "R8 rd unchanged", cpu_rd_data, held);

    for (int t = 0; t < 60; t++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) rx_unit(s, 8'($urandom));
      else tx_unit(s, 16'($urandom));
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule